// File: doc/BRIEF.md
# CAN Bit Timing Engine

This block turns a system clock into the time base of a CAN bit. A prescaler divides the clock into time quanta. Each bit is then sequenced as one synchronisation quantum, a first timing segment (propagation plus first phase) and a second phase segment. The engine emits a pulse on every quantum, a pulse at the sample point, and a pulse on the last clock of every bit.

A single-cycle resynchronisation pulse, produced by the bit stream logic on a recessive-to-dominant transition, moves the sample point. When the pulse falls in the first segment, that segment is stretched. When it falls in the second segment, that segment is shortened. The correction never exceeds the programmed jump width.

Timing comes from a packed 32-bit configuration word. Every field holds its value minus one. The timing fields can only be written while the controller is held in configuration mode. The low byte holds an unrelated clock-select code that can be written at any time.

Top module: `can_bit_timer`

## Requirements
- R1: The configuration word holds the clock-select code in bits 7:0, the second segment length minus 1 in bits 10:8, the jump width minus 1 in bits 13:12, the prescaler minus 1 in bits 25:16 and the first segment length minus 1 in bits 31:28. `tqTick` pulses for one cycle every (prescaler field + 1) clock cycles while running.
- R2: A bit lasts 1 + T1 + T2 quanta. `bitStb` pulses with the final quantum tick of the bit, and the next bit begins in the sync segment.
- R3: `sampleStb` pulses with the final quantum tick of the first segment, 1 + T1 quanta after the bit starts. `segState` reads 0 in sync, 1 in the first segment and 2 in the second segment.
- R4: A decoded first segment below 4 quanta is raised to 4. A decoded second segment below 2 quanta is raised to 2.
- R5: Writes to configuration bytes 1 to 3 take effect only while `confMode` is high. Outside that mode they are discarded and not stored.
- R6: A write with byte enable 0 set updates `clkSel` on the next clock edge in any mode, and it leaves all timing fields unchanged.
- R7: While `confMode` is high, no quantum tick occurs and the engine rests in the sync segment. After `confMode` falls, a bit starts with a fresh prescaler, so the first tick comes (prescaler field + 1) cycles later.
- R8: A resync pulse during the first segment, in its k-th quantum (k counting from 1), lengthens that segment by min(k, SJW) quanta.
- R9: A resync pulse during the second segment, with r quanta of the segment remaining (the current one included), shortens that segment by min(r, SJW) quanta. The segment never ends before the quantum in progress.
- R10: Only the first resync pulse of a bit is honoured. A pulse during the sync quantum changes nothing and still uses up the bit's resynchronisation.
- R11: After reset `clkSel` is 0, all configuration fields are 0 (T1 = 4, T2 = 2, SJW = 1, prescaler 1), the engine is in sync, and no strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| confMode | input | 1 | Controller held in configuration mode; engine idle |
| cfgWe | input | 1 | Configuration write strobe |
| cfgBe | input | 4 | Byte enables for the configuration word |
| cfgWdata | input | 32 | Configuration write data |
| rxEdge | input | 1 | Single-cycle recessive-to-dominant edge pulse |
| tqTick | output | 1 | One-cycle pulse at the end of each time quantum |
| sampleStb | output | 1 | Sample point pulse |
| bitStb | output | 1 | Last-cycle-of-bit pulse |
| segState | output | 2 | Current segment: 0 sync, 1 first, 2 second |
| clkSel | output | 8 | Stored clock-select code |

## Verification
Every fault in the prescaler, the quantum counter or the stored segment lengths moves `sampleStb` or `bitStb` away from its expected cycle. The shift appears no later than the end of the first bit after `confMode` falls, so each case measures the first sample point, the first bit end and the length of the following bit in clock cycles. A wrong correction or a lost resync-used flag shows as a sample point or bit end displaced by a whole number of quanta within the same bit. Writes that should have been discarded are exposed one bit later, when the bit length comes out wrong.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  // Field placement inside the configuration word (fixed by the register format)
  localparam int T2_LSB  = 8;
  localparam int T2_W    = 3;
  localparam int SJW_LSB = 12;
  localparam int SJW_W   = 2;
  localparam int BRP_LSB = 16;
  localparam int BRP_W   = 10;
  localparam int T1_LSB  = 28;
  localparam int T1_W    = 4;
  localparam int CS_W    = 8;
  localparam int T1_MIN  = 4;
  localparam int T2_MIN  = 2;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_T1   = 2'd1,
    SEG_T2   = 2'd2
  } seg_e;

  // Control to datapath strobes
  typedef struct packed {
    logic run;
    logic qClear;
  } ctlStb_t;
endpackage

// File: rtl/cbt_datapath.sv
module cbt_datapath
  import cbt_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 confMode,
  input  logic                 cfgWe,
  input  logic [BYTES-1:0]     cfgBe,
  input  logic [8*BYTES-1:0]   cfgWdata,
  input  ctlStb_t              ctl,
  output logic                 tick,
  output logic [LEN_W-1:0]     qc,
  output logic [LEN_W-1:0]     t1Len,
  output logic [LEN_W-1:0]     t2Len,
  output logic [LEN_W-1:0]     sjwLen,
  output logic [CS_W-1:0]      clkSel
);
  logic [7:0]         cfgByte [BYTES];
  logic [8*BYTES-1:0] cfgWord;
  logic [BRP_W-1:0]   brpM1;
  logic [BRP_W-1:0]   pc;
  logic [LEN_W-1:0]   t1Raw, t2Raw;
  logic               unusedRsvd;

  // Byte 0 (clock select) is writable at any time; timing bytes only in config mode
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    localparam bit ANYTIME = (b == 0);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfgByte[b] <= '0;
      else if (cfgWe && cfgBe[b] && (ANYTIME || confMode))
        cfgByte[b] <= cfgWdata[8*b +: 8];
    end
    assign cfgWord[8*b +: 8] = cfgByte[b];
  end

  assign unusedRsvd = ^{cfgWord[27:26], cfgWord[15:14], cfgWord[11]};
  assign clkSel     = cfgWord[CS_W-1:0];
  assign brpM1      = cfgWord[BRP_LSB +: BRP_W];

  always_comb begin
    t1Raw  = LEN_W'(cfgWord[T1_LSB +: T1_W]) + LEN_W'(1);
    t2Raw  = LEN_W'(cfgWord[T2_LSB +: T2_W]) + LEN_W'(1);
    t1Len  = (t1Raw < LEN_W'(T1_MIN)) ? LEN_W'(T1_MIN) : t1Raw;
    t2Len  = (t2Raw < LEN_W'(T2_MIN)) ? LEN_W'(T2_MIN) : t2Raw;
    sjwLen = LEN_W'(cfgWord[SJW_LSB +: SJW_W]) + LEN_W'(1);
  end

  assign tick = ctl.run && (pc == brpM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pc <= '0;
    else if (!ctl.run || tick) pc <= '0;
    else                       pc <= pc + BRP_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     qc <= '0;
    else if (!ctl.run || ctl.qClear) qc <= '0;
    else if (tick)                  qc <= qc + LEN_W'(1);
  end
endmodule

// File: rtl/cbt_control.sv
module cbt_control
  import cbt_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             confMode,
  input  logic             rxEdge,
  input  logic             tick,
  input  logic [LEN_W-1:0] qc,
  input  logic [LEN_W-1:0] t1Len,
  input  logic [LEN_W-1:0] t2Len,
  input  logic [LEN_W-1:0] sjwLen,
  output ctlStb_t          ctl,
  output logic             sampleStb,
  output logic             bitStb,
  output logic [1:0]       segState
);
  seg_e             seg;
  logic [LEN_W-1:0] t1Cur, t2Cur, t1Eff, t2Eff;
  logic [LEN_W-1:0] e1, ext, e2, shr, t2Sh;
  logic             resyncUsed, edgeOk, endSync, run;

  always_comb begin
    run    = !confMode;
    edgeOk = run && rxEdge && !resyncUsed;
    // first segment: phase error is the quanta elapsed in it, current one included
    e1     = qc + LEN_W'(1);
    ext    = (e1 < sjwLen) ? e1 : sjwLen;
    t1Eff  = t1Cur + ((edgeOk && seg == SEG_T1) ? ext : '0);
    // second segment: phase error is the quanta still to go, current one included
    e2     = t2Cur - qc;
    shr    = (e2 < sjwLen) ? e2 : sjwLen;
    t2Sh   = t2Cur - shr;
    t2Eff  = t2Cur;
    if (edgeOk && seg == SEG_T2) t2Eff = (t2Sh > qc) ? t2Sh : qc + LEN_W'(1);
    endSync   = tick && (seg == SEG_SYNC);
    sampleStb = tick && (seg == SEG_T1) && (qc == t1Eff - LEN_W'(1));
    bitStb    = tick && (seg == SEG_T2) && (qc == t2Eff - LEN_W'(1));
    ctl.run    = run;
    ctl.qClear = endSync || sampleStb || bitStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seg        <= SEG_SYNC;
      t1Cur      <= LEN_W'(T1_MIN);
      t2Cur      <= LEN_W'(T2_MIN);
      resyncUsed <= 1'b0;
    end else if (!run || bitStb) begin
      seg        <= SEG_SYNC;
      t1Cur      <= t1Len;
      t2Cur      <= t2Len;
      resyncUsed <= 1'b0;
    end else begin
      t1Cur <= t1Eff;
      t2Cur <= t2Eff;
      if (edgeOk)         resyncUsed <= 1'b1;
      if (endSync)        seg <= SEG_T1;
      else if (sampleStb) seg <= SEG_T2;
    end
  end

  assign segState = seg;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import cbt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        confMode,
  input  logic        cfgWe,
  input  logic [3:0]  cfgBe,
  input  logic [31:0] cfgWdata,
  input  logic        rxEdge,
  output logic        tqTick,
  output logic        sampleStb,
  output logic        bitStb,
  output logic [1:0]  segState,
  output logic [7:0]  clkSel
);
  localparam int LEN_W = $clog2((1 << T1_W) + (1 << SJW_W) + 1);
  localparam int BYTES = 4;

  ctlStb_t          ctl;
  logic [LEN_W-1:0] qc, t1Len, t2Len, sjwLen;

  cbt_datapath #(.LEN_W(LEN_W), .BYTES(BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .confMode(confMode), .cfgWe(cfgWe), .cfgBe(cfgBe),
    .cfgWdata(cfgWdata), .ctl(ctl), .tick(tqTick), .qc(qc), .t1Len(t1Len),
    .t2Len(t2Len), .sjwLen(sjwLen), .clkSel(clkSel)
  );

  cbt_control #(.LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rstN(rstN), .confMode(confMode), .rxEdge(rxEdge), .tick(tqTick),
    .qc(qc), .t1Len(t1Len), .t2Len(t2Len), .sjwLen(sjwLen), .ctl(ctl),
    .sampleStb(sampleStb), .bitStb(bitStb), .segState(segState)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
  input logic       clk,
  input logic       rstN,
  input logic       confMode,
  input logic       cfgWe,
  input logic [3:0] cfgBe,
  input logic       tqTick,
  input logic       sampleStb,
  input logic       bitStb,
  input logic [1:0] segState,
  input logic [7:0] clkSel
);
  a_r1_strobes_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb || bitStb) |-> tqTick);
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStb && bitStb));
  a_r2_bit_restarts_sync: assert property (@(posedge clk) disable iff (!rstN)
    bitStb |=> segState == 2'd0);
  a_r3_sample_enters_t2: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> segState == 2'd2);
  a_r3_seg_legal: assert property (@(posedge clk) disable iff (!rstN)
    segState != 2'd3);
  a_r7_hold_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    confMode |-> !tqTick);
  a_r7_hold_sync: assert property (@(posedge clk) disable iff (!rstN)
    confMode |=> segState == 2'd0);
  a_r6_clksel_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWe && cfgBe[0]) |=> $stable(clkSel));
endmodule

bind can_bit_timer cbt_checker u_chk (
  .clk(clk), .rstN(rstN), .confMode(confMode), .cfgWe(cfgWe), .cfgBe(cfgBe),
  .tqTick(tqTick), .sampleStb(sampleStb), .bitStb(bitStb),
  .segState(segState), .clkSel(clkSel)
);

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        confMode = 1'b1;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgBe = 4'h0;
  logic [31:0] cfgWdata = '0;
  logic        rxEdge = 1'b0;
  logic        tqTick, sampleStb, bitStb;
  logic [1:0]  segState;
  logic [7:0]  clkSel;

  int checks = 0;
  int errors = 0;
  int mS, mB, mB2, mTicks, mFirst;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rstN(rstN), .confMode(confMode), .cfgWe(cfgWe), .cfgBe(cfgBe),
    .cfgWdata(cfgWdata), .rxEdge(rxEdge), .tqTick(tqTick), .sampleStb(sampleStb),
    .bitStb(bitStb), .segState(segState), .clkSel(clkSel)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R1 layout
  function automatic logic [31:0] pack(input int t1f, input int t2f, input int sjwf,
                                       input int brpf, input int cs);
    logic [31:0] w = '0;
    w[31:28] = 4'(t1f);
    w[25:16] = 10'(brpf);
    w[13:12] = 2'(sjwf);
    w[10:8]  = 3'(t2f);
    w[7:0]   = 8'(cs);
    return w;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Expected sample-point quantum count and bit length in quanta
  function automatic void expBit(input int t1, input int t2, input int sjw, input int q,
                                 output int s, output int b);
    int qc, e, sh, t2n;
    s = 1 + t1;
    b = 1 + t1 + t2;
    if (q >= 1 && q <= t1) begin               // R8
      s += imin(q, sjw);
      b += imin(q, sjw);
    end else if (q > t1 && q <= t1 + t2) begin // R9
      qc  = q - 1 - t1;
      e   = t2 - qc;
      sh  = imin(e, sjw);
      t2n = ((t2 - sh) <= qc) ? qc + 1 : t2 - sh;
      b   = 1 + t1 + t2n;
    end
  endfunction

  task automatic writeCfg(input logic [3:0] be, input logic [31:0] d);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgBe = be; cfgWdata = d;
    @(posedge clk); #1;
    cfgWe = 1'b0; cfgBe = 4'h0;
  endtask

  // Releases config mode, runs two bits, returns to config mode.
  task automatic measure(input int e1c, input int e2c, input int wj,
                         input logic [3:0] wbe, input logic [31:0] wd);
    int j = 0;
    int nb = 0;
    mS = -1; mB = -1; mB2 = -1; mTicks = 0; mFirst = -1;
    @(posedge clk); #1;
    confMode = 1'b0;
    rxEdge = (e1c == 0) || (e2c == 0);
    cfgWe = (wj == 0); cfgBe = wbe; cfgWdata = wd;
    forever begin
      @(negedge clk);
      if (tqTick) begin
        if (mFirst < 0) mFirst = j;
        if (nb == 0) mTicks++;
      end
      if (sampleStb && mS < 0) mS = j;
      if (bitStb) begin
        nb++;
        if (nb == 1) mB = j;
        else begin mB2 = j; break; end
      end
      if (j > 60000) break;
      @(posedge clk); #1;
      j++;
      rxEdge = (j == e1c) || (j == e2c);
      cfgWe = (j == wj);
    end
    @(posedge clk); #1;
    confMode = 1'b1; rxEdge = 1'b0; cfgWe = 1'b0; cfgBe = 4'h0;
  endtask

  // Runs a case with the given (already loaded) fields; eq = edge quantum, -1 none
  task automatic runCheck(input string tag, input int t1f, input int t2f, input int sjwf,
                          input int brpf, input int eq1, input int eq2,
                          input int wj, input logic [3:0] wbe, input logic [31:0] wd);
    int t1, t2, sjw, brp, s, b, off, e1c, e2c;
    t1  = (t1f + 1 < 4) ? 4 : t1f + 1;   // R4
    t2  = (t2f + 1 < 2) ? 2 : t2f + 1;   // R4
    sjw = sjwf + 1;
    brp = brpf + 1;
    off = $urandom % brp;
    e1c = (eq1 < 0) ? -1 : eq1 * brp + off;
    e2c = (eq2 < 0) ? -1 : eq2 * brp + ((off + 1) % brp);
    expBit(t1, t2, sjw, eq1, s, b);
    measure(e1c, e2c, wj, wbe, wd);
    check({"R7 first tick ", tag}, mFirst, brp - 1);
    check({"R3 sample point ", tag}, mS, s * brp - 1);
    check({"R2 bit end ", tag}, mB, b * brp - 1);
    check({"R1 ticks per bit ", tag}, mTicks, b);
    check({"R2 next bit length ", tag}, mB2 - mB, (1 + t1 + t2) * brp);
  endtask

  task automatic loadRun(input string tag, input int t1f, input int t2f, input int sjwf,
                         input int brpf, input int eq1, input int eq2);
    writeCfg(4'hF, pack(t1f, t2f, sjwf, brpf, 0));
    runCheck(tag, t1f, t2f, sjwf, brpf, eq1, eq2, -1, 4'h0, '0);
  endtask

  initial begin : watchdog
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int bad;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 segState", segState, 0);
    check("R11 strobes", {sampleStb, bitStb, tqTick}, 0);
    check("R11 clkSel", clkSel, 0);
    // R7 idle while held in config mode
    bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (tqTick || segState != 2'd0) bad++;
    end
    check("R7 idle in config mode", bad, 0);
    // R11 default fields: T1=4, T2=2, prescaler 1
    runCheck("R11 defaults", 0, 0, 0, 0, -1, -1, -1, 4'h0, '0);

    // R4 clamps
    loadRun("R4 clamp", 1, 0, 0, 2, -1, -1);
    // Maximum fields
    loadRun("R1 max fields", 15, 7, 3, 1023, -1, -1);
    // R8 lengthening
    loadRun("R8 ext limited", 7, 3, 1, 2, 5, -1);
    loadRun("R8 ext first quantum", 7, 3, 3, 1, 1, -1);
    // R9 shortening
    loadRun("R9 short by sjw", 5, 5, 3, 2, 8, -1);
    loadRun("R9 short clamped", 5, 5, 3, 2, 11, -1);
    loadRun("R9 last quantum", 4, 3, 3, 0, 9, -1);
    // R10 sync edge consumes, then later edge ignored
    loadRun("R10 sync edge", 7, 3, 1, 2, 0, 4);
    loadRun("R10 second edge", 9, 4, 3, 1, 2, 6);

    // R5 timing write while running is discarded
    writeCfg(4'hF, pack(6, 2, 1, 1, 8'h11));
    runCheck("R5 run write", 6, 2, 1, 1, -1, -1, 3, 4'hE, pack(12, 6, 3, 4, 0));
    runCheck("R5 not stored", 6, 2, 1, 1, -1, -1, -1, 4'h0, '0);
    // R6 byte-0 write in config mode leaves timing
    writeCfg(4'h1, pack(1, 1, 1, 9, 8'h5A));
    @(negedge clk);
    check("R6 clkSel config mode", clkSel, 8'h5A);
    runCheck("R6 timing kept", 6, 2, 1, 1, -1, -1, 2, 4'h1, pack(0, 0, 0, 0, 8'hC3));
    check("R6 clkSel running", clkSel, 8'hC3);

    // Random mix
    for (int i = 0; i < 24; i++) begin
      int t1f, t2f, sjwf, brpf, t1, t2, l, r, eq1, eq2;
      t1f = $urandom % 16; t2f = $urandom % 8; sjwf = $urandom % 4; brpf = $urandom % 6;
      t1 = (t1f + 1 < 4) ? 4 : t1f + 1;
      t2 = (t2f + 1 < 2) ? 2 : t2f + 1;
      l = 1 + t1 + t2;
      r = $urandom % (l + 1);
      eq1 = (r == l) ? -1 : r;
      eq2 = (eq1 >= 0 && eq1 + 1 <= t1 && ($urandom % 2) == 1) ? eq1 + 1 : -1;
      loadRun("R8 R9 random", t1f, t2f, sjwf, brpf, eq1, eq2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule